// File: doc/BRIEF.md
# Exact-Cycle Channel Schedule Monitor

This monitor watches one point-to-point channel between a producing endpoint and a consuming endpoint. It compares the observed timing against a schedule fixed by parameters: the cycle of the producer's send, the cycle of the consumer's receive, and the cycle at which each endpoint halts. A free-running cycle counter starts at zero on the first clock edge after reset is released. Each expected event must occur on exactly its scheduled cycle. There is no tolerance window. The monitor does not check data values and drives no traffic.

Any event that arrives before its slot, is missing at its slot, or repeats after it has matched latches a sticky error with a 4-bit code. The code names both the event and the kind of fault. The pass flag rises once every scheduled event has matched cleanly and the counter has moved beyond the latest halt cycle. The monitor also compares the parameters with each other: a receive cycle other than the send cycle plus the channel latency raises a configuration flag, and pass can then never rise.

Top module: `timed_sched_monitor`

## Requirements
- R1: While reset is high and on the first cycle after it, err, err_code and pass are all 0. Whenever err is 0, err_code is 0.
- R2: A trace in which every event falls exactly on its scheduled cycle produces no error. For such a trace, pass is 0 through the edge at cycle LAST (the latest halt cycle) and 1 after the edge at cycle LAST+1. This holds for any consistent schedule.
- R3: An event strobe seen before its scheduled cycle sets err at that edge. err_code[3:2] holds the event index (0 send, 1 receive, 2 producer halt, 3 consumer halt) and err_code[1:0] holds 1 (early).
- R4: An event that has not matched by its scheduled cycle sets err at the edge of that cycle, with err_code[1:0] = 2 (late).
- R5: A strobe for an event that has already matched sets err with err_code[1:0] = 3 (unexpected).
- R6: Errors are sticky. The first error's code is held until reset, and later faults do not change it. When several faults occur on the same cycle, the one with the lowest event index is reported.
- R7: Halt inputs are levels. A halt event is the first cycle the level is high, and a halt that stays high afterwards is not a fault. A halt that first rises early reports the early code.
- R8: cfg_err is 1 one cycle after reset is released when RECV_AT differs from SEND_AT + LATENCY. While cfg_err is 1, pass stays 0.
- R9: pass and err are never 1 together. An error detected after pass has risen clears pass at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_send | input | 1 | Producer send strobe |
| rx_recv | input | 1 | Consumer receive strobe |
| tx_halt | input | 1 | Producer halted (level) |
| rx_halt | input | 1 | Consumer halted (level) |
| err | output | 1 | Sticky timing error |
| err_code | output | 4 | Event index [3:2], fault kind [1:0] |
| pass | output | 1 | All events matched, past last halt cycle |
| cfg_err | output | 1 | Schedule parameters inconsistent |

## Verification
A slot tracker with a wrong matched bit shows up at the ports in two ways. It may report a spurious late fault at its scheduled cycle. It may also report an unexpected fault, with the wrong index, on the next strobe. Either way err and err_code change one edge after the cycle concerned. A counter that is off by one moves every on-time event to early or late, so err is already wrong at cycle 3. A fault in the pass condition appears at cycle LAST+1, one edge late or early. The bench therefore records err and pass after every edge of every trace rather than only at the end.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam int NUM_EVENTS = 4;
  localparam int IDX_W = $clog2(NUM_EVENTS);

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_EARLY = 2'd1,
    KIND_LATE  = 2'd2,
    KIND_EXTRA = 2'd3
  } fault_kind_e;
endpackage

// File: rtl/tsm_cycle_counter.sv
module tsm_cycle_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cycle
);
  localparam logic [CW-1:0] TOP = '1;

  // saturating so a long idle tail never wraps onto a scheduled slot
  always_ff @(posedge clk) begin
    if (rst) cycle <= '0;
    else if (cycle != TOP) cycle <= cycle + 1'b1;
  end
endmodule

// File: rtl/tsm_event_slot.sv
module tsm_event_slot
  import tsm_pkg::*;
#(
  parameter int CW = 8,
  parameter int AT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cycle,
  input  logic          strobe,
  output logic          matched,
  output fault_kind_e   fault
);
  localparam logic [CW-1:0] AT_C = CW'(AT);

  always_comb begin
    fault = KIND_NONE;
    if (strobe) begin
      if (matched)          fault = KIND_EXTRA;
      else if (cycle < AT_C) fault = KIND_EARLY;
      else if (cycle > AT_C) fault = KIND_LATE;
    end else if (!matched && cycle == AT_C) begin
      fault = KIND_LATE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) matched <= 1'b0;
    else if (strobe && !matched && cycle == AT_C) matched <= 1'b1;
  end
endmodule

// File: rtl/timed_sched_monitor.sv
module timed_sched_monitor
  import tsm_pkg::*;
#(
  parameter int CW        = 8,
  parameter int LATENCY   = 1,
  parameter int SEND_AT   = 3,
  parameter int RECV_AT   = 4,
  parameter int TX_END_AT = 10,
  parameter int RX_END_AT = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_send,
  input  logic       rx_recv,
  input  logic       tx_halt,
  input  logic       rx_halt,
  output logic       err,
  output logic [3:0] err_code,
  output logic       pass,
  output logic       cfg_err
);
  localparam int END_MAX = (TX_END_AT > RX_END_AT) ? TX_END_AT : RX_END_AT;
  localparam int XFER_MAX = (SEND_AT > RECV_AT) ? SEND_AT : RECV_AT;
  localparam int LAST_AT = (END_MAX > XFER_MAX) ? END_MAX : XFER_MAX;
  localparam logic [CW-1:0] LAST_C = CW'(LAST_AT);
  localparam bit CFG_BAD = (RECV_AT != SEND_AT + LATENCY);

  logic [CW-1:0] cycle;
  logic tx_halt_d, rx_halt_d;
  logic [NUM_EVENTS-1:0] strobes;
  logic [NUM_EVENTS-1:0] matched;
  fault_kind_e fault [NUM_EVENTS];

  logic           any_fault;
  logic [IDX_W-1:0] first_idx;
  fault_kind_e    first_kind;

  tsm_cycle_counter #(.CW(CW)) u_cnt (.clk(clk), .rst(rst), .cycle(cycle));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_halt_d <= 1'b0;
      rx_halt_d <= 1'b0;
    end else begin
      tx_halt_d <= tx_halt;
      rx_halt_d <= rx_halt;
    end
  end

  assign strobes = {rx_halt & ~rx_halt_d, tx_halt & ~tx_halt_d, rx_recv, tx_send};

  for (genvar g = 0; g < NUM_EVENTS; g++) begin : g_slot
    localparam int SLOT_AT = (g == 0) ? SEND_AT :
                             (g == 1) ? RECV_AT :
                             (g == 2) ? TX_END_AT : RX_END_AT;
    tsm_event_slot #(.CW(CW), .AT(SLOT_AT)) u_slot (
      .clk(clk), .rst(rst), .cycle(cycle), .strobe(strobes[g]),
      .matched(matched[g]), .fault(fault[g])
    );
  end

  // lowest event index wins on a same-cycle tie
  always_comb begin
    any_fault  = 1'b0;
    first_idx  = '0;
    first_kind = KIND_NONE;
    for (int i = NUM_EVENTS - 1; i >= 0; i--) begin
      if (fault[i] != KIND_NONE) begin
        any_fault  = 1'b1;
        first_idx  = IDX_W'(i);
        first_kind = fault[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err      <= 1'b0;
      err_code <= '0;
      pass     <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      cfg_err <= CFG_BAD;
      if (!err && any_fault) begin
        err      <= 1'b1;
        err_code <= {first_idx, first_kind};
      end
      pass <= (&matched) && !any_fault && !err && !CFG_BAD && (cycle > LAST_C);
    end
  end
endmodule

// File: rtl/tsm_checker.sv
module tsm_checker (
  input logic       clk,
  input logic       rst,
  input logic       err,
  input logic [3:0] err_code,
  input logic       pass,
  input logic       cfg_err
);
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst) !err |-> err_code == 4'd0); // R1
  AST_KIND_SET: assert property (@(posedge clk) disable iff (rst) err |-> err_code[1:0] != 2'd0); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) err |=> err); // R6
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst) err |=> $stable(err_code)); // R6
  AST_CFG_NO_PASS: assert property (@(posedge clk) disable iff (rst) cfg_err |-> !pass); // R8
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (rst) pass |-> !err); // R9
endmodule

bind timed_sched_monitor tsm_checker u_chk (
  .clk(clk), .rst(rst), .err(err), .err_code(err_code), .pass(pass), .cfg_err(cfg_err)
);

// File: tb/timed_sched_monitor_test.sv
`timescale 1ns/1ps
module timed_sched_monitor_test;
  localparam int HORIZON = 16;
  localparam int LAST = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_send = 0, rx_recv = 0, tx_halt = 0, rx_halt = 0;
  logic r_send = 0, r_recv = 0, r_thalt = 0, r_rhalt = 0;
  logic err, pass, cfg_err;
  logic [3:0] err_code;
  logic r_err, r_pass, r_cfg;
  logic [3:0] r_code;
  logic b_err, b_pass, b_cfg;
  logic [3:0] b_code;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  timed_sched_monitor uut (
    .clk(clk), .rst(rst), .tx_send(tx_send), .rx_recv(rx_recv), .tx_halt(tx_halt), .rx_halt(rx_halt),
    .err(err), .err_code(err_code), .pass(pass), .cfg_err(cfg_err));

  timed_sched_monitor #(.SEND_AT(7), .RECV_AT(8), .TX_END_AT(8), .RX_END_AT(10)) u_rev (
    .clk(clk), .rst(rst), .tx_send(r_send), .rx_recv(r_recv), .tx_halt(r_thalt), .rx_halt(r_rhalt),
    .err(r_err), .err_code(r_code), .pass(r_pass), .cfg_err(r_cfg));

  timed_sched_monitor #(.RECV_AT(5)) u_bad (
    .clk(clk), .rst(rst), .tx_send(tx_send), .rx_recv(rx_recv), .tx_halt(tx_halt), .rx_halt(rx_halt),
    .err(b_err), .err_code(b_code), .pass(b_pass), .cfg_err(b_cfg));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected first fault per requirements R3-R7; returns code, sets cycle
  function automatic int expect_code(input int t[4], input int dup, input int sch[4], output int fcyc);
    bit m[4];
    for (int i = 0; i < 4; i++) m[i] = 0;
    fcyc = -1;
    for (int c = 0; c < HORIZON; c++) begin
      for (int i = 0; i < 4; i++) begin
        bit s;
        int k;
        s = (t[i] == c) || (i == 0 && dup == c);
        k = 0;
        if (s) begin
          if (m[i]) k = 3;
          else if (c < sch[i]) k = 1;
          else if (c > sch[i]) k = 2;
          else m[i] = 1;
        end else if (!m[i] && c == sch[i]) k = 2;
        if (k != 0) begin
          fcyc = c;
          return i * 4 + k;
        end
      end
    end
    return 0;
  endfunction

  // t[i]: strobe cycle (halts: first high cycle), -1 never; dup: second send cycle
  task automatic run_trace(input bit rev, input int t[4], input int dup, input string req);
    int sch[4];
    int fc, code, ec;
    bit err_ok, pass_ok, bad_ok;
    int err_bad_c, pass_bad_c;
    if (rev) sch = '{7, 8, 8, 10};
    else     sch = '{3, 4, 10, 8};
    code = expect_code(t, dup, sch, fc);
    err_ok = 1; pass_ok = 1; bad_ok = 1; err_bad_c = -1; pass_bad_c = -1;
    @(negedge clk);
    rst = 1;
    {tx_send, rx_recv, tx_halt, rx_halt} = '0;
    {r_send, r_recv, r_thalt, r_rhalt} = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 0;
    for (int c = 0; c < HORIZON; c++) begin
      logic s0, s1, h0, h1;
      s0 = (t[0] == c) || (dup == c);
      s1 = (t[1] == c);
      h0 = (t[2] >= 0) && (c >= t[2]);
      h1 = (t[3] >= 0) && (c >= t[3]);
      if (rev) {r_send, r_recv, r_thalt, r_rhalt} = {s0, s1, h0, h1};
      else     {tx_send, rx_recv, tx_halt, rx_halt} = {s0, s1, h0, h1};
      @(posedge clk);
      @(negedge clk);
      begin
        bit e_exp, p_exp, e_act, p_act;
        e_exp = (fc >= 0) && (c >= fc);
        p_exp = (c >= LAST + 1) && ((fc < 0) || (c < fc));
        e_act = rev ? r_err : err;
        p_act = rev ? r_pass : pass;
        if (e_act != e_exp && err_ok) begin err_ok = 0; err_bad_c = c; end
        if (p_act != p_exp && pass_ok) begin pass_ok = 0; pass_bad_c = c; end
        if (!rev && (b_pass !== 1'b0)) bad_ok = 0;
      end
    end
    ec = rev ? int'(r_code) : int'(err_code);
    check(ec == code, {req, " err_code"}, ec, code);
    check(err_ok, {req, " err timeline cycle"}, err_bad_c, fc);
    check(pass_ok, {req, " pass timeline cycle"}, pass_bad_c, LAST + 1);
    if (!rev) begin
      check(bad_ok, "R8 u_bad pass stays low", int'(b_pass), 0);
      check(b_cfg == 1'b1, "R8 cfg_err on bad schedule", int'(b_cfg), 1);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(err == 0 && err_code == 0 && pass == 0, "R1 reset outputs", int'({err, err_code, pass}), 0);
    check(cfg_err == 0, "R1 cfg_err in reset", int'(cfg_err), 0);

    run_trace(0, '{3, 4, 10, 8}, -1, "R2 forward on-time, R7 halts held");
    check(cfg_err == 0, "R8 cfg_err clear on good schedule", int'(cfg_err), 0);
    run_trace(1, '{7, 8, 8, 10}, -1, "R2 reverse on-time");
    run_trace(0, '{2, 4, 10, 8}, -1, "R3 early send");
    run_trace(0, '{3, -1, 10, 8}, -1, "R4 missing receive");
    run_trace(0, '{3, 5, 10, 8}, -1, "R4 late receive");
    run_trace(0, '{3, 4, 10, 8}, 6, "R5 repeated send");
    run_trace(0, '{1, 1, 10, 8}, -1, "R6 same-cycle tie");
    run_trace(0, '{-1, 2, 10, 8}, -1, "R6 first error kept");
    run_trace(0, '{3, 4, 10, 7}, -1, "R7 consumer halt early");
    run_trace(0, '{3, 4, 11, 8}, -1, "R7 producer halt late");
    run_trace(0, '{3, 4, 10, 8}, 13, "R9 error after pass");

    for (int n = 0; n < 24; n++) begin
      int tt[4];
      int base[4];
      int dp;
      bit rv;
      rv = ($urandom_range(3) == 0);
      if (rv) base = '{7, 8, 8, 10};
      else    base = '{3, 4, 10, 8};
      for (int i = 0; i < 4; i++) begin
        int d;
        d = $urandom_range(5);
        tt[i] = base[i] + ((d == 0) ? -1 : (d == 1) ? 1 : 0);
      end
      dp = ($urandom_range(4) == 0) ? int'($urandom_range(HORIZON - 1)) : -1;
      run_trace(rv, tt, dp, "R2/R3/R4/R5 random trace");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule